// File: doc/BRIEF.md
# Paged Address Translation Unit

This block converts a logical address into a physical address through a small page table kept in registers. The upper bits of the logical address select a page, and the lower bits give the byte position inside that page. All pages have the same power-of-two size, so each table entry holds only a frame number. The physical address is that frame number with the in-page offset placed below it.

Each entry also has three status bits: present, write-protected and modified. A request to a page that is not present returns a page fault. A write to a write-protected page returns a protection fault. A write that succeeds marks the page as modified. Software fills and refills entries through a separate load port. Filling an entry clears its modified bit.

Every request gets one registered response in the next cycle. The response carries the physical address, the two fault flags and the modified state of the page.

Top module: `page_xlate_unit`

## Requirements
- R1: When `req_valid` is high in a cycle, `resp_valid` is high in the next cycle, and in only that cycle. The page number is `req_addr[M-1:N]` and the offset is `req_addr[N-1:0]`.
- R2: A request that raises no fault returns `resp_phys = {frame, offset}`. With M=4, N=1 and pages 0..3 loaded with frames 5, 6, 1, 3, logical 0 maps to 0xA, 1 to 0xB, 5 to 0x3 and 6 to 0x6.
- R3: A request to a page whose present bit is 0 raises `resp_page_fault` and returns `resp_phys` = 0.
- R4: A write to a present, write-protected page raises `resp_prot_fault` and returns `resp_phys` = 0. A read of that page translates normally.
- R5: At most one fault flag is high in any response. A write to a page that is both not present and write-protected reports only the page fault.
- R6: A write that raises no fault sets the page's modified bit. `resp_dirty` reports the modified bit as it stands after the access. A faulted request reports 0 and does not set the bit.
- R7: A table load (`tbl_we`) writes the frame, present and write-protect bits of entry `tbl_idx` and clears its modified bit. A request in the same cycle sees the entry's old contents, and the clear wins over a modified-bit set from that request.
- R8: After reset, no response is valid and every entry is not present, so any request raises a page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is a write |
| req_addr | input | M | Logical address |
| tbl_we | input | 1 | Load a table entry |
| tbl_idx | input | M-N | Entry to load |
| tbl_frame | input | FW | Frame number to load |
| tbl_present | input | 1 | Present bit to load |
| tbl_wprot | input | 1 | Write-protect bit to load |
| resp_valid | output | 1 | Response strobe |
| resp_phys | output | FW+N | Physical address, 0 on a fault |
| resp_page_fault | output | 1 | Page not present |
| resp_prot_fault | output | 1 | Write to a protected page |
| resp_dirty | output | 1 | Modified bit after the access |

## Verification
The bench probes a write to a page that is both not present and protected. A design with the wrong fault priority would raise the protection flag there, or both flags. It writes a protected page and then reads that page again. A design that marks the page modified without checking for a fault would report the page as modified on the read. It reloads an entry in the same cycle as a write to that entry. A design that gives the write priority over the reload, or that translates through the new entry, would return the wrong address or leave the modified bit set. The bench also checks the worked translation values, including a mapping where a higher logical address lands at a lower physical address. These values would expose a mis-ordered concatenation or a wrong split point.

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int M  = 4,
  parameter int N  = 1,
  parameter int FW = M - N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [M-1:0]      req_addr,
  input  logic              tbl_we,
  input  logic [M-N-1:0]    tbl_idx,
  input  logic [FW-1:0]     tbl_frame,
  input  logic              tbl_present,
  input  logic              tbl_wprot,
  output logic              resp_valid,
  output logic [FW+N-1:0]   resp_phys,
  output logic              resp_page_fault,
  output logic              resp_prot_fault,
  output logic              resp_dirty
);
  localparam int PW    = M - N;
  localparam int DEPTH = 1 << PW;

  logic [FW-1:0]    frame_q [DEPTH];
  logic [DEPTH-1:0] present_q, wprot_q, dirty_q;

  logic [PW-1:0] page;
  logic [N-1:0]  offset;
  logic          hit, blocked, ok;

  assign page    = req_addr[M-1:N];
  assign offset  = req_addr[N-1:0];
  assign hit     = present_q[page];
  assign blocked = hit & req_write & wprot_q[page];
  assign ok      = hit & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) frame_q[i] <= '0;
      present_q       <= '0;
      wprot_q         <= '0;
      dirty_q         <= '0;
      resp_valid      <= 1'b0;
      resp_phys       <= '0;
      resp_page_fault <= 1'b0;
      resp_prot_fault <= 1'b0;
      resp_dirty      <= 1'b0;
    end else begin
      resp_valid      <= req_valid;
      resp_page_fault <= req_valid & ~hit;
      resp_prot_fault <= req_valid & blocked;
      resp_phys       <= (req_valid & ok) ? {frame_q[page], offset} : '0;
      resp_dirty      <= req_valid & ok & (dirty_q[page] | req_write);
      if (req_valid && req_write && ok) dirty_q[page] <= 1'b1;
      if (tbl_we) begin
        frame_q[tbl_idx]   <= tbl_frame;
        present_q[tbl_idx] <= tbl_present;
        wprot_q[tbl_idx]   <= tbl_wprot;
        dirty_q[tbl_idx]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_xlate_unit_chk.sv
module page_xlate_unit_chk #(
  parameter int M  = 4,
  parameter int N  = 1,
  parameter int FW = M - N
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            resp_valid,
  input logic [FW+N-1:0] resp_phys,
  input logic            resp_page_fault,
  input logic            resp_prot_fault,
  input logic            resp_dirty
);
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_page_fault || resp_prot_fault) |-> (resp_phys == '0));
  a_r4_prot_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !resp_prot_fault);
  a_r5_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_page_fault && resp_prot_fault));
  a_r6_dirty_clean_only: assert property (@(posedge clk) disable iff (!rst_n)
    resp_dirty |-> (resp_valid && !resp_page_fault && !resp_prot_fault));
endmodule

bind page_xlate_unit page_xlate_unit_chk #(.M(M), .N(N), .FW(FW)) u_chk (.*);

// File: tb/tb_page_xlate_unit.sv
module tb_page_xlate_unit;
  localparam int M = 4, N = 1, FW = 3, PW = M - N, AW = FW + N;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, tbl_we = 0, tbl_present = 0, tbl_wprot = 0;
  logic [M-1:0]  req_addr = '0;
  logic [PW-1:0] tbl_idx = '0;
  logic [FW-1:0] tbl_frame = '0;
  logic          resp_valid, resp_page_fault, resp_prot_fault, resp_dirty;
  logic [AW-1:0] resp_phys;

  always #2 clk = ~clk;

  page_xlate_unit #(.M(M), .N(N), .FW(FW)) dut (.*);

  typedef struct {
    logic [AW-1:0] phys;
    logic pf, prf, d;
    string tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;

  always @(negedge clk) if (rst_n && resp_valid) begin
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL R1 unexpected response: got valid=1 expected valid=0");
    end else begin
      exp_t e;
      e = sb.pop_front();
      if (resp_phys !== e.phys || resp_page_fault !== e.pf ||
          resp_prot_fault !== e.prf || resp_dirty !== e.d) begin
        errors++;
        $display("FAIL %s: got phys=%h pf=%b prf=%b d=%b expected phys=%h pf=%b prf=%b d=%b",
                 e.tag, resp_phys, resp_page_fault, resp_prot_fault, resp_dirty,
                 e.phys, e.pf, e.prf, e.d);
      end
    end
  end

  task automatic access(input logic w, input logic [M-1:0] a, input logic [AW-1:0] ph,
                        input logic pf, input logic prf, input logic d, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a;
    e.phys = ph; e.pf = pf; e.prf = prf; e.d = d; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1 req_valid = 0; req_write = 0;
  endtask

  task automatic load(input logic [PW-1:0] i, input logic [FW-1:0] f,
                      input logic p, input logic wp);
    @(negedge clk);
    tbl_we = 1; tbl_idx = i; tbl_frame = f; tbl_present = p; tbl_wprot = wp;
    @(posedge clk); #1 tbl_we = 0;
  endtask

  task automatic load_and_write(input logic [PW-1:0] i, input logic [FW-1:0] f,
                                input logic [M-1:0] a, input logic [AW-1:0] ph,
                                input logic d, input string tag);
    exp_t e;
    @(negedge clk);
    tbl_we = 1; tbl_idx = i; tbl_frame = f; tbl_present = 1; tbl_wprot = 0;
    req_valid = 1; req_write = 1; req_addr = a;
    e.phys = ph; e.pf = 0; e.prf = 0; e.d = d; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1 tbl_we = 0; req_valid = 0; req_write = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (resp_valid !== 0 || resp_page_fault !== 0 || resp_prot_fault !== 0) begin
          errors++;
          $display("FAIL R8 reset state: got valid=%b pf=%b prf=%b expected 0 0 0",
                   resp_valid, resp_page_fault, resp_prot_fault);
        end
        rst_n = 1;
        access(0, 4'd0, 4'h0, 1, 0, 0, "R8 empty table faults");
        load(0, 5, 1, 0); load(1, 6, 1, 0); load(2, 1, 1, 0); load(3, 3, 1, 0);
        access(0, 4'd0, 4'hA, 0, 0, 0, "R2 logical 0");
        access(0, 4'd1, 4'hB, 0, 0, 0, "R2 logical 1");
        access(0, 4'd5, 4'h3, 0, 0, 0, "R2 logical 5");
        access(0, 4'd6, 4'h6, 0, 0, 0, "R2 logical 6");
        access(0, 4'd15, 4'h0, 1, 0, 0, "R3 unmapped page 7");
        access(1, 4'd2, 4'hC, 0, 0, 1, "R6 clean write sets dirty");
        access(0, 4'd3, 4'hD, 0, 0, 1, "R6 dirty seen on read");
        load(4, 2, 1, 1);
        access(0, 4'd8, 4'h4, 0, 0, 0, "R4 read of protected page");
        access(1, 4'd9, 4'h0, 0, 1, 0, "R4 write to protected page");
        access(0, 4'd9, 4'h5, 0, 0, 0, "R6 faulted write leaves clean");
        load(5, 7, 0, 1);
        access(1, 4'd10, 4'h0, 1, 0, 0, "R5 page fault priority");
        load(1, 6, 1, 0);
        access(0, 4'd2, 4'hC, 0, 0, 0, "R7 reload clears dirty");
        load_and_write(0, 4, 4'd0, 4'hA, 1, "R7 same-cycle uses old entry");
        access(0, 4'd0, 4'h8, 0, 0, 0, "R7 load wins over dirty set");
        repeat (2) @(negedge clk);
        checks++;
        if (resp_valid !== 0) begin
          errors++;
          $display("FAIL R1 idle cycle: got valid=%b expected 0", resp_valid);
        end
        checks++;
        if (sb.size() != 0) begin
          errors++;
          $display("FAIL R1 missing responses: got %0d pending expected 0", sb.size());
        end
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule